// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block keeps a record of why the chip last went through reset, so that the first instructions at the reset entry point can read it and branch to the right start-up path. It watches four cause pulses: power-on, watchdog timeout, external reset pin, and software-requested reset. The software request arrives from a reset-request bit in a standby/control register. Each cause sets its own flag. The flags live in a power-on-only reset domain, so they survive the reset that they describe.

A cause is recorded only while the chip's reset state machine signals that it is in its reset state. A flag then stays set until software reads the register. That read returns every flag and clears all of them together at the next clock edge. When power-on is recorded, any stale cause flags left over from before power was lost are discarded. A cause that arrives in the same cycle as a clearing read is still recorded.

Top module: `rst_cause_hold`

## Requirements
- R1: While `rst` (power-on domain reset, synchronous, active high) is asserted, every flag clears. A read after reset returns 0.
- R2: During a read, `rdata_o` carries bit 3 = power-on, bit 2 = watchdog, bit 1 = external pin, bit 0 = software, with all bits above bit 3 at 0. When no read is in progress, `rdata_o` is all zero.
- R3: A cause pulse sets its flag at the next clock edge only if `in_rst_state_i` is high in that cycle. A pulse while `in_rst_state_i` is low changes no flag.
- R4: When several causes are active in one capturing cycle, all of their flags are set. No priority is applied.
- R5: A set flag stays set through later cycles, through further causes and after `in_rst_state_i` falls, until a read clears it.
- R6: A read (`sel_i` and `rd_i` both high) returns the flag values held before the clear, and leaves all flags at 0 after the clock edge.
- R7: If a cause is captured in the same cycle as a clearing read, the flag for that cause is set after the edge.
- R8: A captured power-on cause sets the power-on flag and clears the other three. Other causes captured in that same cycle are still set.
- R9: If only one of `sel_i` and `rd_i` is high, no read takes place and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on domain reset, synchronous, active high |
| in_rst_state_i | input | 1 | High while the reset state machine is in its reset state |
| por_evt_i | input | 1 | Power-on cause pulse |
| wdt_evt_i | input | 1 | Watchdog reset detector cause pulse |
| ext_evt_i | input | 1 | Conditioned external reset pin cause pulse |
| sw_evt_i | input | 1 | Software reset request from a standby/control register write |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data; zero outside a read |

## Verification
The capture path is driven with the following patterns:
- single causes, which show that each bit lands in its own position;
- several causes at once, which rules out a hidden priority encoder;
- causes presented outside the reset state, which separates gated capture from free-running capture.

The read path is exercised in three ways:
- with select alone and with strobe alone, which shows that only a full read clears;
- back-to-back reads, which show both the value returned before the clear and the empty state after it;
- a read in the same cycle as a new cause, which shows that the set beats the clear.

Power-on is tried both alone and together with another cause, which separates the discard of stale flags from the loss of a fresh one.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int unsigned NCAUSE  = 4;
    localparam int unsigned IDX_SW  = 0;
    localparam int unsigned IDX_EXT = 1;
    localparam int unsigned IDX_WDT = 2;
    localparam int unsigned IDX_POR = 3;

    typedef struct packed {
        logic por;
        logic wdt;
        logic ext;
        logic sw;
    } cause_t;

    typedef logic [NCAUSE-1:0] cause_bits_t;

    function automatic cause_bits_t cause_to_bits(cause_t c);
        cause_bits_t b;
        b[IDX_POR] = c.por;
        b[IDX_WDT] = c.wdt;
        b[IDX_EXT] = c.ext;
        b[IDX_SW]  = c.sw;
        return b;
    endfunction
endpackage

// File: rtl/rstc_capture.sv
module rstc_capture
    import rstc_pkg::*;
(
    input  logic        in_rst_state_i,
    input  cause_t      raw_i,
    output cause_bits_t cap_o
);
    cause_bits_t raw_bits;

    always_comb begin
        raw_bits = cause_to_bits(raw_i);
        cap_o    = in_rst_state_i ? raw_bits : '0;
    end
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
    import rstc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cause_bits_t cap_i,
    input  logic        clr_i,
    output cause_bits_t flags_o
);
    cause_bits_t flags_q;
    cause_bits_t base;
    logic        wipe;

    always_comb begin
        wipe = clr_i || cap_i[IDX_POR];
        base = wipe ? '0 : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= base | cap_i;
    end

    assign flags_o = flags_q;

    // Captured causes are present after the edge, even with a clearing read
    assert_set_R7: assert property (@(posedge clk) disable iff (rst)
        (cap_i != '0) |=> ((flags_q & $past(cap_i)) == $past(cap_i)));

    // Without a read or power-on, nothing that was set is lost
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !cap_i[IDX_POR]) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // A read with no new cause leaves every flag cleared
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && cap_i == '0) |=> (flags_q == '0));

    // Nothing sets without a captured cause
    assert_nospont_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0));

    // Power-on discards stale causes and keeps the coincident ones
    assert_por_R8: assert property (@(posedge clk) disable iff (rst)
        cap_i[IDX_POR] |=> (flags_q == $past(cap_i)));
endmodule

// File: rtl/rstc_readport.sv
module rstc_readport
    import rstc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              sel_i,
    input  logic              rd_i,
    input  cause_bits_t       flags_i,
    output logic              rd_hit_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned PAD_W = DATA_W - NCAUSE;

    always_comb begin
        rd_hit_o = sel_i && rd_i;
        rdata_o  = rd_hit_o ? {{PAD_W{1'b0}}, flags_i} : '0;
    end
endmodule

// File: rtl/rst_cause_hold.sv
module rst_cause_hold
    import rstc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_rst_state_i,
    input  logic              por_evt_i,
    input  logic              wdt_evt_i,
    input  logic              ext_evt_i,
    input  logic              sw_evt_i,
    input  logic              sel_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o
);
    cause_t      raw;
    cause_bits_t cap;
    cause_bits_t flags;
    logic        rd_hit;

    always_comb begin
        raw.por = por_evt_i;
        raw.wdt = wdt_evt_i;
        raw.ext = ext_evt_i;
        raw.sw  = sw_evt_i;
    end

    rstc_capture u_capture (
        .in_rst_state_i (in_rst_state_i),
        .raw_i          (raw),
        .cap_o          (cap)
    );

    rstc_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap),
        .clr_i   (rd_hit),
        .flags_o (flags)
    );

    rstc_readport #(.DATA_W(DATA_W)) u_read (
        .sel_i    (sel_i),
        .rd_i     (rd_i),
        .flags_i  (flags),
        .rd_hit_o (rd_hit),
        .rdata_o  (rdata_o)
    );

    // A cause seen outside the reset state must not show up
    assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_rst_state_i && !rd_hit) |=> (flags == $past(flags)));

    // A half-formed access never clears
    assert_noread_R9: assert property (@(posedge clk) disable iff (rst)
        (!(sel_i && rd_i) && !in_rst_state_i) |=> $stable(flags));
endmodule

// File: tb/tb_rst_cause_hold.sv
module tb_rst_cause_hold;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int NVEC   = 18;

    // {in_rst, por, wdt, ext, sw, sel, rd, exp[3:0] (por,wdt,ext,sw)}
    localparam logic [10:0] VEC [NVEC] = '{
        11'b1_0010_00_0000, // R3 ext captured in reset state
        11'b0_0000_11_0010, // R6 read returns ext, clears
        11'b0_0000_11_0000, // R6 cleared
        11'b0_0100_00_0000, // R3 watchdog outside reset state
        11'b0_0000_11_0000, // R3 ignored
        11'b1_0101_00_0000, // R4 wdt+sw together
        11'b0_0000_10_0000, // R9 select only, R2 zero outside read
        11'b0_0000_01_0000, // R9 strobe only
        11'b1_0010_00_0000, // R5 add ext
        11'b0_0000_11_0111, // R5 R4 R9 all kept
        11'b1_0001_11_0000, // R7 cause with read
        11'b0_0000_11_0001, // R7 set won
        11'b1_0100_00_0000, // R8 stale watchdog
        11'b1_1000_00_0000, // R8 power-on alone
        11'b0_0000_11_1000, // R8 stale cleared
        11'b1_1010_00_0000, // R8 power-on with ext
        11'b0_0000_11_1010, // R8 coincident kept
        11'b0_0000_11_0000  // R6 final clear
    };
    localparam int VREQ [NVEC] = '{3,6,6,3,3,4,9,9,5,5,7,7,8,8,8,8,8,6};

    logic clk = 1'b0;
    logic rst;
    logic in_rst, por, wdt, ext, sw, sel, rd;
    logic [DATA_W-1:0] rdata;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rst_cause_hold #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .in_rst_state_i(in_rst),
        .por_evt_i(por), .wdt_evt_i(wdt), .ext_evt_i(ext), .sw_evt_i(sw),
        .sel_i(sel), .rd_i(rd), .rdata_o(rdata)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
        end
    endtask

    task automatic drive(input logic [10:0] v);
        @(negedge clk);
        {in_rst, por, wdt, ext, sw, sel, rd} = v[10:4];
        #(CLK_P/4);
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {in_rst, por, wdt, ext, sw, sel, rd} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state reads zero
        drive(11'b0_0000_11_0000);
        check("R1", '0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            check($sformatf("R%0d vec%0d", VREQ[i], i), {{(DATA_W-4){1'b0}}, VEC[i][3:0]});
        end

        // R5 flag survives reset state ending and idle cycles
        drive(11'b1_0100_00_0000);
        drive(11'b0_0000_00_0000);
        drive(11'b0_0000_00_0000);
        drive(11'b0_0000_11_0000);
        check("R5", 32'h4);

        // R2 no read: zero while flag held
        drive(11'b1_1111_00_0000);
        drive(11'b0_0000_00_0000);
        check("R2", '0);
        drive(11'b0_0000_11_0000);
        check("R4", 32'hF);

        // R1 reset mid-run clears flags
        drive(11'b1_0011_00_0000);
        @(negedge clk);
        rst = 1'b1;
        {in_rst, por, wdt, ext, sw, sel, rd} = '0;
        @(negedge clk);
        rst = 1'b0;
        drive(11'b0_0000_11_0000);
        check("R1", '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule